// File: doc/BRIEF.md
# Strided Gapped Memory Copy Engine

The engine moves a programmed number of bytes from one memory region to another. Each region is seen as a series of rows. A row holds a run of payload beats, and a gap of skipped beats follows it. The source and the destination each have their own row width and gap, so a single transfer can re-pack data from one stride into another. One example is gathering a sub-rectangle out of a wide surface into a dense buffer, or the reverse.

Software programs the engine through a small word-addressed register port. It writes the two base addresses, a byte count, a geometry word for each side and a control word, and then writes the start register. The memory side moves one 16-byte beat per cycle. The read port is combinational, and the same beat goes out on the write port in the same cycle. When the last beat has been written, a one-cycle interrupt pulse marks completion. A sticky done bit in the status register records the same event.

Top module: `gapcopy_engine`

## Requirements
- R1: After reset every register reads 0, the interrupt is low and no memory write is issued.
- R2: Register 3 (source) and register 4 (destination) hold a byte address divided by 8. The engine multiplies each by 8 and then clears the low 4 bits, so it starts on a 16-byte beat boundary.
- R3: Register 6 (source geometry) and register 7 (destination geometry) each hold a row width in bits 15:0 and a gap in bits 31:16, both counted in 16-byte beats. After a side has moved `width` beats, its pointer skips `gap` beats and a new row begins.
- R4: Register 5 gives the payload size in bytes. The size does not count gap bytes and is rounded down to a multiple of 16. Exactly floor(size/16) beats are written.
- R5: Payload beat k is read from source beat `s0 + (k/wi)*(wi+gi) + k%wi` and written to destination beat `d0 + (k/wo)*(wo+go) + k%wo`. Here s0 and d0 are the base beats, and wi, gi, wo, go are the two sides' widths and gaps.
- R6: Writing register 1 with bit 0 set starts a transfer only if bit 3 of the control word (register 0) is set. Otherwise the write has no effect: no busy, no writes, no interrupt.
- R7: Status bit 0 (busy) is high from the cycle after the start write until completion. While busy, writes to registers 0, 1 and 3 to 7 are ignored.
- R8: The interrupt `irq` is high for exactly one cycle. That cycle comes two cycles after the last beat write (or two cycles after the start when no beat moves), and it is the first cycle in which busy reads 0.
- R9: Status bit 1 (done) is set at the edge where `irq` rises and cleared by writing 1 to bit 1 of register 2. If the clear and the set fall on the same edge, the set wins.
- R10: A width of zero on either side, or a size below 16, ends the transfer with no memory write and still raises `irq` and done.
- R11: Beats move on consecutive cycles with no bubbles. A transfer of N beats holds the write strobe high for exactly the N cycles that follow the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| irq | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Beat read request |
| mem_rd_addr | output | ADDR_W | Byte address of the beat being read |
| mem_rd_data | input | 8*BEAT_BYTES | Read beat, valid in the same cycle |
| mem_wr_en | output | 1 | Beat write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the beat being written |
| mem_wr_data | output | 8*BEAT_BYTES | Beat being written |

## Verification
Two functions can land on the same clock edge: the hardware setting the done bit as a transfer completes, and software writing 1 to clear that bit. The bench finds this edge by counting from the start write. It issues the clear so that the clear is sampled in the cycle where busy is still high but no beat remains, which is the edge where the set occurs. It then reads status in the cycle where `irq` is high and expects done to still read 1. Around this case the bench sweeps every combination of small widths, gaps and sizes, and compares the whole destination window against an arithmetic index map.

// File: rtl/gapcopy_pkg.sv
package gapcopy_pkg;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_KICK  = 3'd1,
      RA_STAT  = 3'd2,
      RA_SRC   = 3'd3,
      RA_DST   = 3'd4,
      RA_COUNT = 3'd5,
      RA_SGEOM = 3'd6,
      RA_DGEOM = 3'd7
   } reg_idx_e;

   typedef struct packed {
      logic [15:0] gap;
      logic [15:0] width;
   } geom_t;

   localparam int unsigned MODE_BIT = 3;
   localparam int unsigned ST_BUSY  = 0;
   localparam int unsigned ST_DONE  = 1;
   localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/gapcopy_walker.sv
module gapcopy_walker
   import gapcopy_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BEAT_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-4:0] base_word,
   input  geom_t             geom,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic              width_zero
);

   localparam int unsigned OFF_W = $clog2(BEAT_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BEAT_BYTES - 1);
   localparam logic [ADDR_W-1:0] BEAT_STEP  = ADDR_W'(BEAT_BYTES);

   logic [ADDR_W-1:0] ptr_q;
   logic [15:0]       left_q;
   logic [15:0]       width_q;
   logic [15:0]       gap_q;
   logic [ADDR_W-1:0] start_addr;
   logic [ADDR_W-1:0] row_skip;
   logic              row_end;

   assign start_addr = {base_word, 3'b000} & ALIGN_MASK;
   assign row_skip   = ADDR_W'({1'b0, gap_q} + 17'd1) << OFF_W;
   assign row_end    = (left_q == 16'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         left_q  <= '0;
         width_q <= '0;
         gap_q   <= '0;
      end else if (load) begin
         ptr_q   <= start_addr;
         left_q  <= geom.width;
         width_q <= geom.width;
         gap_q   <= geom.gap;
      end else if (step) begin
         if (row_end) begin
            ptr_q  <= ptr_q + row_skip;
            left_q <= width_q;
         end else begin
            ptr_q  <= ptr_q + BEAT_STEP;
            left_q <= left_q - 16'd1;
         end
      end
   end

   assign ptr        = ptr_q;
   assign width_zero = (width_q == 16'd0);

   // R3: the row counter never exceeds the row width
   p_left_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= width_q);

   // R2: a loaded pointer sits on a beat boundary
   p_ptr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ptr_q[OFF_W-1:0] == '0));

   // R3: inside a row the pointer advances by exactly one beat
   p_in_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !row_end) |=> (ptr_q == $past(ptr_q) + BEAT_STEP));

endmodule

// File: rtl/gapcopy_seq.sv
module gapcopy_seq #(
   parameter int unsigned CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count_beats,
   input  logic             in_zero,
   input  logic             out_zero,
   output logic             busy,
   output logic             beat,
   output logic             finish,
   output logic             irq
);

   logic             busy_q;
   logic             irq_q;
   logic [CNT_W-1:0] remain_q;

   assign beat   = busy_q && (remain_q != '0) && !in_zero && !out_zero;
   assign finish = busy_q && !beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         irq_q    <= 1'b0;
         remain_q <= '0;
      end else begin
         irq_q <= finish;
         if (start) begin
            busy_q   <= 1'b1;
            remain_q <= count_beats;
         end else if (beat) begin
            remain_q <= remain_q - CNT_W'(1);
         end else if (busy_q) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign irq  = irq_q;

   // R8: completion pulse lasts a single cycle
   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R8: busy only drops together with the completion pulse
   p_busy_fall_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> irq_q);

   // R4: every moved beat consumes exactly one unit of the count
   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      beat |=> (remain_q == $past(remain_q) - CNT_W'(1)));

   // R11: beats only move while busy
   p_beat_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> busy_q);

endmodule

// File: rtl/gapcopy_regs.sv
module gapcopy_regs
   import gapcopy_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 4,
   parameter int unsigned CNT_W  = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              finish,
   output logic              start,
   output logic [ADDR_W-4:0] src_base,
   output logic [ADDR_W-4:0] dst_base,
   output logic [CNT_W-1:0]  count_beats,
   output geom_t             src_geom,
   output geom_t             dst_geom
);

   logic [31:0]       ctrl_q;
   logic [ADDR_W-4:0] src_q;
   logic [ADDR_W-4:0] dst_q;
   logic [31:0]       count_q;
   geom_t             sgeom_q;
   geom_t             dgeom_q;
   logic              done_q;
   logic              cfg_we;
   logic              done_clr;

   assign cfg_we   = reg_we && !busy;
   assign done_clr = reg_we && (reg_addr == RA_STAT) && reg_wdata[ST_DONE];
   assign start    = cfg_we && (reg_addr == RA_KICK) && reg_wdata[0] && ctrl_q[MODE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         count_q <= '0;
         sgeom_q <= '0;
         dgeom_q <= '0;
      end else if (cfg_we) begin
         case (reg_addr)
            RA_CTRL:  ctrl_q  <= reg_wdata;
            RA_SRC:   src_q   <= reg_wdata[ADDR_W-4:0];
            RA_DST:   dst_q   <= reg_wdata[ADDR_W-4:0];
            RA_COUNT: count_q <= reg_wdata;
            RA_SGEOM: sgeom_q <= reg_wdata;
            RA_DGEOM: dgeom_q <= reg_wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (finish)   done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
   end

   always_comb begin
      case (reg_addr)
         RA_CTRL:  reg_rdata = ctrl_q;
         RA_STAT:  reg_rdata = {30'd0, done_q, busy};
         RA_SRC:   reg_rdata = 32'(src_q);
         RA_DST:   reg_rdata = 32'(dst_q);
         RA_COUNT: reg_rdata = count_q;
         RA_SGEOM: reg_rdata = sgeom_q;
         RA_DGEOM: reg_rdata = dgeom_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign src_base    = src_q;
   assign dst_base    = dst_q;
   assign count_beats = count_q[31:OFF_W];
   assign src_geom    = sgeom_q;
   assign dst_geom    = dgeom_q;

   // R7: configuration is frozen while a transfer runs
   p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(src_q) && $stable(dst_q) && $stable(count_q)
                && $stable(sgeom_q) && $stable(dgeom_q) && $stable(ctrl_q)));

   // R7: no restart while busy
   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

   // R9: completion always leaves done set, even against a clear
   p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> done_q);

endmodule

// File: rtl/gapcopy_engine.sv
module gapcopy_engine
   import gapcopy_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BEAT_BYTES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [2:0]              reg_addr,
   input  logic [31:0]             reg_wdata,
   output logic [31:0]             reg_rdata,
   output logic                    irq,
   output logic                    mem_rd_en,
   output logic [ADDR_W-1:0]       mem_rd_addr,
   input  logic [8*BEAT_BYTES-1:0] mem_rd_data,
   output logic                    mem_wr_en,
   output logic [ADDR_W-1:0]       mem_wr_addr,
   output logic [8*BEAT_BYTES-1:0] mem_wr_data
);

   localparam int unsigned OFF_W = $clog2(BEAT_BYTES);
   localparam int unsigned CNT_W = 32 - OFF_W;

   if (BEAT_BYTES < 8 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_beat
      $error("BEAT_BYTES must be a power of two of at least 8");
   end
   if (ADDR_W < 8 || ADDR_W > 35) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and 35");
   end

   logic              start;
   logic              busy;
   logic              beat;
   logic              finish;
   logic [CNT_W-1:0]  count_beats;
   logic [ADDR_W-4:0] base_w  [NUM_SIDES];
   geom_t             geom_w  [NUM_SIDES];
   logic [ADDR_W-1:0] ptr_w   [NUM_SIDES];
   logic              zero_w  [NUM_SIDES];

   gapcopy_regs #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .busy        (busy),
      .finish      (finish),
      .start       (start),
      .src_base    (base_w[0]),
      .dst_base    (base_w[1]),
      .count_beats (count_beats),
      .src_geom    (geom_w[0]),
      .dst_geom    (geom_w[1])
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      gapcopy_walker #(
         .ADDR_W     (ADDR_W),
         .BEAT_BYTES (BEAT_BYTES)
      ) u_walk (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (start),
         .base_word  (base_w[s]),
         .geom       (geom_w[s]),
         .step       (beat),
         .ptr        (ptr_w[s]),
         .width_zero (zero_w[s])
      );
   end

   gapcopy_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .count_beats (count_beats),
      .in_zero     (zero_w[0]),
      .out_zero    (zero_w[1]),
      .busy        (busy),
      .beat        (beat),
      .finish      (finish),
      .irq         (irq)
   );

   assign mem_rd_en   = beat;
   assign mem_rd_addr = ptr_w[0];
   assign mem_wr_en   = beat;
   assign mem_wr_addr = ptr_w[1];
   assign mem_wr_data = mem_rd_data;

   // R10: a zero-width side never produces a memory write
   p_zero_width_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (zero_w[0] || zero_w[1])) |-> !mem_wr_en);

   // R1: no memory traffic outside a transfer
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_wr_en && !mem_rd_en));

endmodule

// File: tb/gapcopy_engine_test.sv
`timescale 1ns/1ps
module gapcopy_engine_test;

   localparam int MEMN = 128;
   localparam int SRC_BEAT = 8;
   localparam int DST_BEAT = 96;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_addr = 3'd0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         irq;
   logic         mem_rd_en;
   logic [31:0]  mem_rd_addr;
   logic [127:0] mem_rd_data;
   logic         mem_wr_en;
   logic [31:0]  mem_wr_addr;
   logic [127:0] mem_wr_data;
   logic [127:0] mem [MEMN];

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gapcopy_engine uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data)
   );

   assign mem_rd_data = mem[mem_rd_addr[10:4]];
   always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr[10:4]] <= mem_wr_data;

   function automatic logic [127:0] init_word(int i);
      return {32'h5EED0000 + 32'(i), 32'(i * 3), 32'(i * 7), 32'(i)};
   endfunction

   function automatic int side_idx(int base, int w, int g, int k);
      return base + (k / w) * (w + g) + (k % w);
   endfunction

   function automatic logic [127:0] expect_dst(int d, int iw, int ig, int ow, int og, int n);
      for (int k = 0; k < n; k++)
         if (side_idx(DST_BEAT, ow, og, k) == d)
            return init_word(side_idx(SRC_BEAT, iw, ig, k));
      return init_word(d);
   endfunction

   task automatic check(bit ok, string req, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic reg_wr(logic [2:0] a, logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < MEMN; i++) mem[i] = init_word(i);
   endtask

   // runs one transfer; called at a negedge
   task automatic run_xfer(int iw, int ig, int ow, int og, int nbytes,
                           int src_reg, bit poke, bit collide);
      int n;
      int neff;
      logic [31:0] rd;
      n = nbytes / 16;
      neff = (iw == 0 || ow == 0) ? 0 : n;
      clear_mem();
      reg_wr(3'd0, 32'h8);
      reg_wr(3'd3, 32'(src_reg));
      reg_wr(3'd4, 32'(DST_BEAT * 2));
      reg_wr(3'd5, 32'(nbytes));
      reg_wr(3'd6, {16'(ig), 16'(iw)});
      reg_wr(3'd7, {16'(og), 16'(ow)});
      reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'd1;
      for (int j = 1; j <= neff + 3; j++) begin
         @(negedge clk);
         reg_we = 1'b0; reg_addr = 3'd2;
         #1;
         // R11: one beat per cycle, strobe high exactly N cycles
         check(mem_wr_en == (j <= neff), "R11", 128'(mem_wr_en), 128'(j <= neff));
         // R7: busy from start until completion
         check(reg_rdata[0] == (j <= neff + 1), "R7", 128'(reg_rdata[0]), 128'(j <= neff + 1));
         // R8: single interrupt cycle two after last beat
         check(irq == (j == neff + 2), "R8", 128'(irq), 128'(j == neff + 2));
         if (j == neff + 2)
            check(reg_rdata[1] == 1'b1, "R9 done set", 128'(reg_rdata[1]), 128'd1);
         if (poke && j == 1) begin reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd99; end
         if (poke && j == 2) begin reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'd1; end
         if (collide && j == neff + 1) begin reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd2; end
      end
      if (poke) begin
         reg_rd(3'd3, rd);
         check(rd == 32'(src_reg), "R7 write ignored while busy", 128'(rd), 128'(src_reg));
      end
      // R3/R5 destination image, including gaps and untouched tail
      for (int d = DST_BEAT; d < MEMN; d++)
         check(mem[d] == expect_dst(d, iw, ig, ow, og, neff), "R3/R5 dst beat",
               mem[d], expect_dst(d, iw, ig, ow, og, neff));
      @(negedge clk);
      reg_wr(3'd2, 32'd2);
      reg_rd(3'd2, rd);
      check(rd[1] == 1'b0, "R9 write-one clear", 128'(rd[1]), 128'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog got=hang exp=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int sizes [4] = '{0, 16, 80, 112};
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         reg_rd(3'(a), rd);
         check(rd == 32'd0, "R1 reg reset", 128'(rd), 128'd0);
      end
      check(!irq && !mem_wr_en, "R1 outputs idle", 128'({irq, mem_wr_en}), 128'd0);

      // R6: start ignored without mode bit
      @(negedge clk);
      reg_wr(3'd5, 32'd64);
      reg_wr(3'd6, 32'h0000_0001);
      reg_wr(3'd7, 32'h0000_0001);
      reg_wr(3'd1, 32'd1);
      for (int j = 0; j < 4; j++) begin
         reg_rd(3'd2, rd);
         check(rd[0] == 1'b0 && !irq && !mem_wr_en, "R6 no start",
               128'({rd[0], irq, mem_wr_en}), 128'd0);
         @(negedge clk);
      end

      // R2: odd base word rounds down to beat; R4: size rounded down
      run_xfer(2, 1, 3, 0, 5 * 16 + 9, SRC_BEAT * 2 + 1, 1'b0, 1'b0);
      // R7: writes and restart during busy ignored
      run_xfer(1, 2, 2, 1, 7 * 16, SRC_BEAT * 2, 1'b1, 1'b0);
      // R9: clear and set on the same edge
      run_xfer(2, 0, 1, 1, 5 * 16, SRC_BEAT * 2, 1'b0, 1'b1);
      run_xfer(0, 0, 1, 0, 4 * 16, SRC_BEAT * 2, 1'b0, 1'b1);

      // R10 (zero widths, small size) and R3/R5 sweep
      for (int iw = 0; iw < 3; iw++)
         for (int ig = 0; ig < 3; ig++)
            for (int ow = 0; ow < 3; ow++)
               for (int og = 0; og < 3; og++)
                  for (int s = 0; s < 4; s++)
                     run_xfer(iw, ig, ow, og, sizes[s], SRC_BEAT * 2, 1'b0, 1'b0);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule